// File: doc/BRIEF.md
# Byte-Addressed Data Memory with Access-Size Control

This block is the data store of a 32-bit core. Every address names one byte and the storage holds 32-bit words. A 2-bit access code selects the operation: a word read, or a write of one byte, one halfword or one whole word. A write changes only the bytes that its size and address select. The other bytes of the addressed word keep their old values.

The storage is split into four byte-wide banks, one for each byte lane of the word. The address is decoded into one write strobe for each lane. Writes take effect on the rising clock edge. The read word is formed combinationally from the four banks, using the word index taken from the address bits just above the byte offset (bits 11:2 at the default depth of 1024 words). Address bits above the index are ignored, so addresses that differ only in those bits refer to the same storage.

Top module: `bytemem_top`

## Requirements
- R1: When `en` is 0, no access code changes the storage, and `rdata` is 0.
- R2: Code 2'b00 with `en` high is a read. `rdata` shows the word at index `addr[11:2]`, and nothing is stored. For any other code, `rdata` is 0.
- R3: Code 2'b01 with `en` high writes `wdata[7:0]` into the byte lane selected by `addr[1:0]`. The order is little-endian: lane k is bits 8k+7:8k of the word.
- R4: Code 2'b10 with `en` high writes `wdata[15:0]` into one halfword. `addr[1]`=0 selects bits 15:0 and `addr[1]`=1 selects bits 31:16. `addr[0]` is ignored.
- R5: Code 2'b11 with `en` high writes all 32 bits of `wdata`. `addr[1:0]` are ignored.
- R6: A byte or halfword write leaves every byte outside its lane unchanged.
- R7: The word index is `addr[11:2]`. Address bits 31:12 are ignored, so two addresses that differ only there access the same word.
- R8: A write commits on the rising clock edge. A read in the following cycle returns the new data.
- R9: While `rst` is high, no write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes while high |
| en | input | 1 | Access enable |
| mc | input | 2 | Access code: 00 read word, 01 write byte, 10 write halfword, 11 write word |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, right-aligned for byte and halfword writes |
| rdata | output | 32 | Read word, combinational; 0 unless a read is enabled |

## Verification
A wrong lane strobe or a misplaced data byte does not show up at the write. It appears only when the affected word is read back: one or more bytes of `rdata` differ from a byte-level reference model. It can therefore stay hidden until that word is read. For this reason the bench reads back all 1024 words after thousands of mixed random writes whose high address bits are also random, so every corruption surfaces before the run ends. Wrong gating by `en` or `rst` shows on the next read of the touched word. A wrong read-data gate shows at once on `rdata`.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;
  typedef enum logic [1:0] {
    MC_RD_WORD = 2'b00,
    MC_WR_BYTE = 2'b01,
    MC_WR_HALF = 2'b10,
    MC_WR_WORD = 2'b11
  } memctl_e;
endpackage

// File: rtl/bytemem_lane_dec.sv
module bytemem_lane_dec
  import bytemem_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mc,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  lane_we,
  output logic [DATA_W-1:0] lane_d
);
  memctl_e          code;
  logic [LANES-1:0] sel;
  logic [OFF_W-1:0] half_off;

  assign code     = memctl_e'(mc);
  assign half_off = {off[OFF_W-1:1], 1'b0};

  always_comb begin
    sel    = '0;
    lane_d = wdata;
    unique case (code)
      MC_WR_BYTE: begin
        sel    = LANES'(1) << off;
        lane_d = {LANES{wdata[7:0]}};
      end
      MC_WR_HALF: begin
        sel    = LANES'(3) << half_off;
        lane_d = {(LANES/2){wdata[15:0]}};
      end
      MC_WR_WORD: sel = '1;
      default:    sel = '0;
    endcase
  end

  assign lane_we = (en && !rst) ? sel : '0;
endmodule

// File: rtl/bytemem_bank.sv
module bytemem_bank #(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       d,
  output logic [7:0]       q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= d;
  end

  assign q = mem[idx];
endmodule

// File: rtl/bytemem_top.sv
module bytemem_top
  import bytemem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [IDX_W-1:0]  idx;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] lane_d;
  logic [DATA_W-1:0] word_q;

  assign idx = addr[OFF_W +: IDX_W];

  bytemem_lane_dec #(.DATA_W(DATA_W)) dec_i (
    .rst     (rst),
    .en      (en),
    .mc      (mc),
    .off     (addr[OFF_W-1:0]),
    .wdata   (wdata),
    .lane_we (lane_we),
    .lane_d  (lane_d)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bytemem_bank #(.DEPTH(DEPTH)) bank_i (
      .clk (clk),
      .we  (lane_we[g]),
      .idx (idx),
      .d   (lane_d[8*g +: 8]),
      .q   (word_q[8*g +: 8])
    );
  end

  assign rdata = (en && memctl_e'(mc) == MC_RD_WORD) ? word_q : '0;
endmodule

// File: rtl/bytemem_chk.sv
module bytemem_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [1:0]        mc,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [LANES-1:0]  lane_we
);
  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (lane_we == '0 && rdata == '0));
  // R2
  read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mc == 2'b00) |-> lane_we == '0);
  // R3
  byte_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mc == 2'b01) |-> ($countones(lane_we) == 1 && lane_we[addr[OFF_W-1:0]]));
  // R4
  half_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mc == 2'b10) |-> ($countones(lane_we) == 2 && lane_we[addr[OFF_W-1:0]]
                             && lane_we[{addr[OFF_W-1:1], 1'b0}]));
  // R5
  word_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mc == 2'b11) |-> lane_we == '1);
  // R8
  word_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mc == 2'b00 && $past(en && mc == 2'b11 && !rst)
     && addr[OFF_W +: IDX_W] == $past(addr[OFF_W +: IDX_W])) |-> rdata == $past(wdata));
  // R9
  reset_no_write_chk: assert property (@(posedge clk) rst |-> lane_we == '0);
endmodule

bind bytemem_top bytemem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .en(en), .mc(mc), .addr(addr),
  .wdata(wdata), .rdata(rdata), .lane_we(lane_we)
);

// File: tb/bytemem_top_tb_top.sv
module bytemem_top_tb_top;
  localparam int DEPTH = 1024;
  localparam int NBYTE = DEPTH * 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  mc = 2'b00;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] ref_mem [NBYTE];

  always #10 clk = ~clk;

  bytemem_top dut_i (
    .clk(clk), .rst(rst), .en(en), .mc(mc),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int base_of(input logic [31:0] a);
    return int'(a[11:2]) * 4;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] a);
    int b = base_of(a);
    return {ref_mem[b+3], ref_mem[b+2], ref_mem[b+1], ref_mem[b]};
  endfunction

  task automatic ref_write(input logic [1:0] c, input logic [31:0] a, input logic [31:0] d);
    int b = base_of(a);
    case (c)
      2'b01: ref_mem[b + int'(a[1:0])] = d[7:0];
      2'b10: begin
        ref_mem[b + (a[1] ? 2 : 0)]     = d[7:0];
        ref_mem[b + (a[1] ? 2 : 0) + 1] = d[15:8];
      end
      2'b11: for (int k = 0; k < 4; k++) ref_mem[b+k] = d[8*k +: 8];
      default: ;
    endcase
  endtask

  task automatic op(input logic e, input logic [1:0] c, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    en = e; mc = c; addr = a; wdata = d;
    @(posedge clk);
    #1;
    en = 1'b0;
    if (e && !rst) ref_write(c, a, d);
  endtask

  task automatic rd(input string req, input logic [31:0] a);
    @(negedge clk);
    en = 1'b1; mc = 2'b00; addr = a; wdata = $urandom;
    #2;
    check(req, rdata, ref_word(a));
    @(posedge clk);
    #1;
    en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rdata", rdata, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // fill every word so the reference is fully defined
    for (int i = 0; i < DEPTH; i++) op(1'b1, 2'b11, i * 4, $urandom);

    // R2: non-read code gives zero on rdata
    @(negedge clk);
    en = 1'b1; mc = 2'b01; addr = 32'h10; wdata = 32'h0;
    #2; check("R2 rdata zero on write code", rdata, 32'h0);
    @(posedge clk); #1; en = 1'b0;
    ref_write(2'b01, 32'h10, 32'h0);

    // R3: each byte lane, little-endian
    for (int k = 0; k < 4; k++) begin
      op(1'b1, 2'b01, 32'h100 + k, 32'hFFFF_FF00 | (8'hA0 + k));
    end
    rd("R3 byte lanes", 32'h100);
    check("R3 lane order", ref_word(32'h100), 32'hA3A2A1A0);

    // R4: halfword with addr[0]=1 ignored
    op(1'b1, 2'b11, 32'h200, 32'h11223344);
    op(1'b1, 2'b10, 32'h203, 32'hDEAD_BEEF);
    rd("R4 upper half, addr0 ignored", 32'h200);
    op(1'b1, 2'b10, 32'h201, 32'h0000_CAFE);
    rd("R4 lower half", 32'h200);
    check("R6 halfword neighbours", ref_word(32'h200), 32'hBEEFCAFE);

    // R5: word write with addr[1:0]=3
    op(1'b1, 2'b11, 32'h303, 32'h5566_7788);
    rd("R5 word ignores offset", 32'h300);

    // R6: byte write keeps the other three bytes
    op(1'b1, 2'b11, 32'h400, 32'h0102_0304);
    op(1'b1, 2'b01, 32'h402, 32'h0000_00EE);
    rd("R6 byte neighbours", 32'h400);

    // R7: high address bits alias
    op(1'b1, 2'b11, 32'hABCD_E500, 32'h0BAD_F00D);
    rd("R7 alias read", 32'h0000_0500);

    // R8: next-cycle readback
    op(1'b1, 2'b11, 32'h600, 32'h1357_9BDF);
    rd("R8 next cycle", 32'h600);

    // R1: enable low, every code, no change
    for (int c = 0; c < 4; c++) op(1'b0, 2'(c), 32'h700, 32'hFFFF_FFFF);
    rd("R1 enable low no write", 32'h700);

    // R9: reset blocks writes
    @(negedge clk); rst = 1'b1;
    op(1'b1, 2'b11, 32'h800, 32'h0);
    op(1'b1, 2'b01, 32'h804, 32'h0);
    @(negedge clk); rst = 1'b0;
    rd("R9 reset blocks word", 32'h800);
    rd("R9 reset blocks byte", 32'h804);

    // random mixed writes, random high bits
    for (int i = 0; i < 4000; i++) begin
      op(($urandom % 8) != 0, 2'(1 + $urandom % 3), $urandom, $urandom);
    end

    // full readback
    for (int i = 0; i < DEPTH; i++) rd("R3 R4 R5 R6 R7 random readback", ($urandom & 32'hFFFF_F000) | (i * 4));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule